// File: doc/BRIEF.md
# Dual-Port Scratch RAM Access Controller

This block sits in front of a small on-chip scratch RAM and serves two requesters. The local port is fast and is shared by the processor core and its DSP unit. It uses virtual addresses and checks every access against the current privilege and DSP mode bits, the address space the access falls in, and the access sizes that requester is allowed to use. The system port serves bus masters, either a DMA engine or a USB host. It uses physical addresses, clears the top three address bits unless they select the top region, and takes a fixed number of cycles per access.

Both ports are valid/ready. A requester raises `*_valid` and must hold every request field stable until it sees `*_ready` high. The handshake completes on the clock edge where valid and ready are both high. Read data, the read-valid strobe and the error pulse all appear in that same cycle. The system port always wins a same-page collision. In that case the local port sees ready low for one cycle and then completes. The RAM responds only inside a window at `RAM_BASE`, and the array itself is held in byte-lane register banks.

Top module: `spr_front`

## Requirements
- R1: With `mode_priv`=1, a core access (`lp_src`=0) is allowed when address bits 31:29 are 000 to 011 (user region) or 101 (second privileged region). Values 100, 110 and 111 give an error.
- R2: With `mode_priv`=0 and `mode_dsp`=0, a core access is allowed only in the user region, and not inside the 64 KB window where `addr[31:16]` equals `UXY_BASE[31:16]`. That window and every other region give an error.
- R3: With `mode_priv`=0 and `mode_dsp`=1, a core access is allowed anywhere in the user region, including that 64 KB window. Region 101 gives an error.
- R4: A DSP access (`lp_src`=1) gives an error if `mode_dsp`=0, if it is a byte access, or if `lp_par`=1 (a parallel transfer). Otherwise it uses the R1 spaces when privileged and the user region when not.
- R5: Size code 0 is byte, 1 is half and 2 is word. Code 3 gives an error, and so does a half access with a set bit 0 or a word access with nonzero bits 1:0. Address bits 28:12 must match `RAM_BASE` on the local port, and bits 31:12 must match it after normalisation on the system port.
- R6: On an error the handshake still completes and the matching `*_err` is high for that one cycle. No write takes place and `*_rvalid` stays low.
- R7: When there is no collision, `lp_ready` is high in the same cycle as `lp_valid`. A permitted read returns the addressed 32-bit word on `lp_rdata` with `lp_rvalid` high in that cycle.
- R8: `sb_ready` goes high in the `SB_LAT`-th (default 3rd) consecutive cycle of `sb_valid`, for one cycle. `sb_rvalid`, `sb_rdata` and `sb_err` are valid in that cycle.
- R9: The DMA requester (`sb_id`=0) may use sizes 0, 1 and 2. The USB requester (`sb_id`=1) may use 0 and 2, and size 1 gives an error.
- R10: A system address whose bits 31:29 are not 111 has those bits replaced by 000 before the window check. A top-region (111) address is kept as it is, so it misses the RAM and gives an error.
- R11: Suppose a local request in the RAM window is valid in the cycle `sb_ready` is high for a system access to the same 1 KB page. Then `lp_ready` is low in that cycle and high in the next. A different page causes no stall.
- R12: A write changes only the byte lanes selected by size and address bits 1:0. Write data sits on its own byte lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_priv | input | 1 | Privileged-mode bit |
| mode_dsp | input | 1 | DSP-enable mode bit |
| lp_valid | input | 1 | Local request valid |
| lp_ready | output | 1 | Local handshake completes |
| lp_src | input | 1 | 0 core, 1 DSP |
| lp_par | input | 1 | DSP parallel-transfer flag |
| lp_write | input | 1 | 1 write, 0 read |
| lp_size | input | 2 | 0 byte, 1 half, 2 word |
| lp_addr | input | 32 | Local virtual address |
| lp_wdata | input | 32 | Local write data, lane aligned |
| lp_rvalid | output | 1 | Local read data valid |
| lp_rdata | output | 32 | Local read word |
| lp_err | output | 1 | Local error pulse |
| sb_valid | input | 1 | System request valid |
| sb_ready | output | 1 | System handshake completes |
| sb_id | input | 1 | 0 DMA, 1 USB host |
| sb_write | input | 1 | 1 write, 0 read |
| sb_size | input | 2 | 0 byte, 1 half, 2 word |
| sb_addr | input | 32 | System physical address |
| sb_wdata | input | 32 | System write data, lane aligned |
| sb_rvalid | output | 1 | System read data valid |
| sb_rdata | output | 32 | System read word |
| sb_err | output | 1 | System error pulse |

## Verification
The bench goes after the mode-dependent space decode. Its targets are the 64 KB DSP window, which must be denied to a plain user core but allowed once the DSP bit is set, and the second privileged region, which must be refused in user mode. A decoder that merged these cases would let a user core read the window or reach region 101. It then tries DSP byte and parallel transfers, USB half-word transfers and misaligned writes. A design that ignored any of these would alter RAM contents, and the bench exposes that by reading back a word the faulty write would have overwritten. It also checks partial writes lane by lane and sends system addresses with a high alias or the top region: a missing normalisation would miss the RAM, and a blanket normalisation would hit it. Finally, a collision timed into the system completion cycle shows whether the local port stalls for exactly one cycle on the same page and not at all on another page.

// File: rtl/spr_pkg.sv
package spr_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_NONE = 2'd3} size_e;

  function automatic logic [3:0] lane_mask(input logic [1:0] sz, input logic [1:0] lo);
    case (size_e'(sz))
      SZ_BYTE: lane_mask = 4'b0001 << lo;
      SZ_HALF: lane_mask = 4'b0011 << lo;
      SZ_WORD: lane_mask = 4'b1111;
      default: lane_mask = 4'b0000;
    endcase
  endfunction

  function automatic logic size_legal(input logic [1:0] sz, input logic [1:0] lo);
    case (size_e'(sz))
      SZ_BYTE: size_legal = 1'b1;
      SZ_HALF: size_legal = (lo[0] == 1'b0);
      SZ_WORD: size_legal = (lo == 2'b00);
      default: size_legal = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/spr_local_check.sv
module spr_local_check #(
  parameter int          RAM_AW   = 12,
  parameter logic [31:0] RAM_BASE = 32'h0500_0000,
  parameter logic [31:0] UXY_BASE = 32'h0500_0000
) (
  input  logic              priv,
  input  logic              dsp_on,
  input  logic              src_dsp,
  input  logic              par,
  input  logic [1:0]        size,
  input  logic [31:0]       addr,
  output logic              deny,
  output logic              in_win,
  output logic [RAM_AW-3:0] idx,
  output logic [3:0]        be
);
  import spr_pkg::*;

  logic [2:0] region;
  logic       in_user, in_p2, in_uxy, space_ok, shape_ok;

  always_comb begin
    region  = addr[31:29];
    in_user = (region[2] == 1'b0);
    in_p2   = (region == 3'b101);
    in_uxy  = in_user && (addr[31:16] == UXY_BASE[31:16]);
    in_win  = (addr[28:RAM_AW] == RAM_BASE[28:RAM_AW]);
    if (!src_dsp) begin
      if (priv)        space_ok = in_user || in_p2;
      else if (dsp_on) space_ok = in_user;
      else             space_ok = in_user && !in_uxy;
    end else begin
      space_ok = dsp_on && !par && (size_e'(size) != SZ_BYTE) &&
                 (priv ? (in_user || in_p2) : in_user);
    end
    shape_ok = size_legal(size, addr[1:0]);
    deny     = !(space_ok && shape_ok && in_win);
    idx      = addr[RAM_AW-1:2];
    be       = lane_mask(size, addr[1:0]);
  end
endmodule

// File: rtl/spr_sys_port.sv
module spr_sys_port #(
  parameter int          RAM_AW   = 12,
  parameter logic [31:0] RAM_BASE = 32'h0500_0000,
  parameter int          SB_LAT   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic              usb,
  input  logic [1:0]        size,
  input  logic [31:0]       addr,
  output logic              done,
  output logic              deny,
  output logic              in_win,
  output logic [RAM_AW-3:0] idx,
  output logic [3:0]        be
);
  import spr_pkg::*;

  localparam int CW = (SB_LAT > 2) ? $clog2(SB_LAT) : 1;
  localparam logic [CW-1:0] LAST = CW'(SB_LAT - 1);

  logic [CW-1:0] cnt;
  logic [31:0]   norm;
  logic          shape_ok;

  always_comb begin
    norm     = (addr[31:29] == 3'b111) ? addr : {3'b000, addr[28:0]};
    in_win   = (norm[31:RAM_AW] == RAM_BASE[31:RAM_AW]);
    shape_ok = size_legal(size, norm[1:0]) && !(usb && size_e'(size) == SZ_HALF);
    deny     = !(shape_ok && in_win);
    idx      = norm[RAM_AW-1:2];
    be       = lane_mask(size, norm[1:0]);
    done     = valid && (cnt == LAST);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (!valid || done) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spr_ram.sv
module spr_ram #(
  parameter int RAM_AW = 12
) (
  input  logic              clk,
  input  logic              a_we,
  input  logic [3:0]        a_be,
  input  logic [RAM_AW-3:0] a_idx,
  input  logic [31:0]       a_wd,
  output logic [31:0]       a_rd,
  input  logic              b_we,
  input  logic [3:0]        b_be,
  input  logic [RAM_AW-3:0] b_idx,
  input  logic [31:0]       b_wd,
  output logic [31:0]       b_rd
);
  localparam int WORDS = 2 ** (RAM_AW - 2);

  for (genvar l = 0; l < 4; l++) begin : g_lane
    logic [7:0] bank [WORDS];
    always_ff @(posedge clk) begin
      if (a_we && a_be[l]) bank[a_idx] <= a_wd[8*l +: 8];
      if (b_we && b_be[l]) bank[b_idx] <= b_wd[8*l +: 8];
    end
    assign a_rd[8*l +: 8] = bank[a_idx];
    assign b_rd[8*l +: 8] = bank[b_idx];
  end
endmodule

// File: rtl/spr_front.sv
module spr_front #(
  parameter int          RAM_BYTES  = 4096,
  parameter int          PAGE_BYTES = 1024,
  parameter logic [31:0] RAM_BASE   = 32'h0500_0000,
  parameter logic [31:0] UXY_BASE   = 32'h0500_0000,
  parameter int          SB_LAT     = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_priv,
  input  logic        mode_dsp,
  input  logic        lp_valid,
  output logic        lp_ready,
  input  logic        lp_src,
  input  logic        lp_par,
  input  logic        lp_write,
  input  logic [1:0]  lp_size,
  input  logic [31:0] lp_addr,
  input  logic [31:0] lp_wdata,
  output logic        lp_rvalid,
  output logic [31:0] lp_rdata,
  output logic        lp_err,
  input  logic        sb_valid,
  output logic        sb_ready,
  input  logic        sb_id,
  input  logic        sb_write,
  input  logic [1:0]  sb_size,
  input  logic [31:0] sb_addr,
  input  logic [31:0] sb_wdata,
  output logic        sb_rvalid,
  output logic [31:0] sb_rdata,
  output logic        sb_err
);
  localparam int RAM_AW = $clog2(RAM_BYTES);
  localparam int PG_AW  = $clog2(PAGE_BYTES);

  logic              l_deny, l_win, s_deny, s_win, s_done, clash;
  logic [RAM_AW-3:0] l_idx, s_idx;
  logic [3:0]        l_be, s_be;
  logic [31:0]       l_rd, s_rd;

  spr_local_check #(.RAM_AW(RAM_AW), .RAM_BASE(RAM_BASE), .UXY_BASE(UXY_BASE)) u_lchk (
    .priv(mode_priv), .dsp_on(mode_dsp), .src_dsp(lp_src), .par(lp_par),
    .size(lp_size), .addr(lp_addr), .deny(l_deny), .in_win(l_win),
    .idx(l_idx), .be(l_be)
  );

  spr_sys_port #(.RAM_AW(RAM_AW), .RAM_BASE(RAM_BASE), .SB_LAT(SB_LAT)) u_sys (
    .clk(clk), .rst_n(rst_n), .valid(sb_valid), .usb(sb_id), .size(sb_size),
    .addr(sb_addr), .done(s_done), .deny(s_deny), .in_win(s_win),
    .idx(s_idx), .be(s_be)
  );

  // same-page arbitration: the system port owns the page in its completion cycle
  always_comb begin
    clash     = lp_valid && s_done && l_win && s_win &&
                (l_idx[RAM_AW-3:PG_AW-2] == s_idx[RAM_AW-3:PG_AW-2]);
    lp_ready  = lp_valid && !clash;
    lp_err    = lp_ready && l_deny;
    lp_rvalid = lp_ready && !l_deny && !lp_write;
    lp_rdata  = lp_rvalid ? l_rd : '0;
    sb_ready  = s_done;
    sb_err    = s_done && s_deny;
    sb_rvalid = s_done && !s_deny && !sb_write;
    sb_rdata  = sb_rvalid ? s_rd : '0;
  end

  spr_ram #(.RAM_AW(RAM_AW)) u_ram (
    .clk(clk),
    .a_we(lp_ready && lp_write && !l_deny), .a_be(l_be), .a_idx(l_idx),
    .a_wd(lp_wdata), .a_rd(l_rd),
    .b_we(s_done && sb_write && !s_deny), .b_be(s_be), .b_idx(s_idx),
    .b_wd(sb_wdata), .b_rd(s_rd)
  );
endmodule

// File: rtl/spr_front_chk.sv
module spr_front_chk #(
  parameter int SB_LAT = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        mode_priv,
  input logic        mode_dsp,
  input logic        lp_valid,
  input logic        lp_ready,
  input logic        lp_src,
  input logic        lp_par,
  input logic [1:0]  lp_size,
  input logic [31:0] lp_addr,
  input logic        lp_rvalid,
  input logic        lp_err,
  input logic        sb_valid,
  input logic        sb_ready,
  input logic        sb_id,
  input logic [1:0]  sb_size,
  input logic        sb_err
);
  logic [7:0] run;
  always_ff @(posedge clk) begin
    if (!rst_n) run <= '0;
    else if (sb_valid && !sb_ready) run <= run + 1'b1;
    else run <= '0;
  end

  p_lp_ready_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lp_ready |-> lp_valid);
  p_lp_resp_handshake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_rvalid || lp_err) |-> lp_ready);
  p_lp_err_no_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(lp_rvalid && lp_err));
  p_sb_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sb_ready |-> (run == 8'(SB_LAT - 1)));
  p_sb_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sb_ready |=> !sb_ready);
  p_stall_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_valid && !lp_ready) |=> (!lp_valid || lp_ready));
  p_priv_bad_region_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_ready && mode_priv && !lp_src && lp_addr[31:29] inside {3'b100, 3'b110, 3'b111}) |-> lp_err);
  p_dsp_byte_par_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_ready && lp_src && (lp_size == 2'd0 || lp_par || !mode_dsp)) |-> lp_err);
  p_usb_half_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_ready && sb_id && sb_size == 2'd1) |-> sb_err);
endmodule

bind spr_front spr_front_chk #(.SB_LAT(SB_LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_priv(mode_priv), .mode_dsp(mode_dsp),
  .lp_valid(lp_valid), .lp_ready(lp_ready), .lp_src(lp_src), .lp_par(lp_par),
  .lp_size(lp_size), .lp_addr(lp_addr), .lp_rvalid(lp_rvalid), .lp_err(lp_err),
  .sb_valid(sb_valid), .sb_ready(sb_ready), .sb_id(sb_id), .sb_size(sb_size),
  .sb_err(sb_err)
);

// File: tb/sim_spr_front.sv
module sim_spr_front;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_priv = 0, mode_dsp = 0;
  logic lp_valid = 0, lp_src = 0, lp_par = 0, lp_write = 0;
  logic [1:0] lp_size = 0;
  logic [31:0] lp_addr = 0, lp_wdata = 0;
  logic sb_valid = 0, sb_id = 0, sb_write = 0;
  logic [1:0] sb_size = 0;
  logic [31:0] sb_addr = 0, sb_wdata = 0;
  logic lp_ready, lp_rvalid, lp_err, sb_ready, sb_rvalid, sb_err;
  logic [31:0] lp_rdata, sb_rdata;

  int n_run = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  spr_front u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic        priv, dsp, src, par, wr;
    logic [1:0]  size;
    logic [31:0] addr, wdata;
    logic        err, rd;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VT [NV] = '{
    '{1,0,0,0,1,2'd2,32'h0500_0000,32'h1122_3344,0,0,32'h0,8'd1},  // R1 write P0
    '{1,0,0,0,1,2'd2,32'h0500_0004,32'h5566_7788,0,0,32'h0,8'd1},  // R1
    '{1,0,0,0,0,2'd2,32'h0500_0000,32'h0,0,1,32'h1122_3344,8'd1},  // R1 read P0
    '{1,0,0,0,0,2'd2,32'hA500_0000,32'h0,0,1,32'h1122_3344,8'd1},  // R1 region 101
    '{1,0,0,0,0,2'd2,32'h8500_0000,32'h0,1,0,32'h0,8'd1},          // R1 region 100 denied
    '{0,0,0,0,0,2'd2,32'h2500_0000,32'h0,0,1,32'h1122_3344,8'd2},  // R2 user alias
    '{0,0,0,0,0,2'd2,32'h0500_0000,32'h0,1,0,32'h0,8'd2},          // R2 DSP window denied
    '{0,1,0,0,0,2'd2,32'h0500_0000,32'h0,0,1,32'h1122_3344,8'd3},  // R3 window allowed
    '{0,1,0,0,0,2'd2,32'hA500_0000,32'h0,1,0,32'h0,8'd3},          // R3 region 101 denied
    '{1,0,1,0,0,2'd2,32'h0500_0000,32'h0,1,0,32'h0,8'd4},          // R4 DSP unit, bit clear
    '{1,1,1,0,1,2'd1,32'hA500_0006,32'hBEEF_0000,0,0,32'h0,8'd4},  // R4 DSP half write
    '{1,1,1,0,1,2'd0,32'h0500_0004,32'h0000_00FF,1,0,32'h0,8'd4},  // R4 DSP byte denied
    '{1,1,1,1,1,2'd2,32'h0500_0004,32'hFFFF_FFFF,1,0,32'h0,8'd4},  // R4 parallel denied
    '{1,0,0,0,1,2'd0,32'h0500_0005,32'h0000_AA00,0,0,32'h0,8'd12}, // R12 byte lane 1
    '{1,0,0,0,0,2'd2,32'h0500_0004,32'h0,0,1,32'hBEEF_AA88,8'd12}, // R12 merged lanes
    '{1,0,0,0,1,2'd2,32'h0500_0002,32'hFFFF_FFFF,1,0,32'h0,8'd5},  // R5 misaligned word
    '{1,0,0,0,1,2'd3,32'h0500_0000,32'hFFFF_FFFF,1,0,32'h0,8'd5},  // R5 size code 3
    '{1,0,0,0,1,2'd2,32'h0500_1000,32'hFFFF_FFFF,1,0,32'h0,8'd5},  // R5 outside window
    '{1,0,0,0,0,2'd2,32'h0500_0000,32'h0,0,1,32'h1122_3344,8'd6},  // R6 nothing written
    '{1,0,0,0,0,2'd2,32'h0500_0004,32'h0,0,1,32'hBEEF_AA88,8'd6}   // R6 nothing written
  };

  task automatic lp_drive(input logic src, input logic wr, input logic [1:0] sz,
                          input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    lp_valid = 1; lp_src = src; lp_par = 0; lp_write = wr; lp_size = sz;
    lp_addr = a; lp_wdata = d;
  endtask

  task automatic lp_idle();
    @(negedge clk);
    lp_valid = 0; lp_write = 0; lp_par = 0;
  endtask

  // one system access; checks ready lands on cycle SB_LAT (3)
  task automatic sb_do(input logic id, input logic wr, input logic [1:0] sz,
                       input logic [31:0] a, input logic [31:0] d,
                       input logic exp_err, input logic [31:0] exp_rd, input string req);
    @(negedge clk);
    sb_valid = 1; sb_id = id; sb_write = wr; sb_size = sz; sb_addr = a; sb_wdata = d;
    for (int k = 0; k < 3; k++) begin
      #2;
      if (k < 2) chk(sb_ready == 0, "R8 early ready", {31'd0, sb_ready}, 32'd0);
      else begin
        chk(sb_ready == 1, "R8 ready on third cycle", {31'd0, sb_ready}, 32'd1);
        chk(sb_err == exp_err, req, {31'd0, sb_err}, {31'd0, exp_err});
        if (!wr && !exp_err) chk(sb_rvalid && sb_rdata == exp_rd, req, sb_rdata, exp_rd);
      end
      @(negedge clk);
    end
    sb_valid = 0; sb_write = 0;
  endtask

  initial begin
    #(20 * 20000);
    chk(0, "watchdog", 32'd0, 32'd1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk(!lp_ready && !lp_err && !sb_ready && !sb_err, "reset idle outputs R7 R8",
        {28'd0, lp_ready, lp_err, sb_ready, sb_err}, 32'd0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      mode_priv = VT[i].priv; mode_dsp = VT[i].dsp;
      lp_valid = 1; lp_src = VT[i].src; lp_par = VT[i].par; lp_write = VT[i].wr;
      lp_size = VT[i].size; lp_addr = VT[i].addr; lp_wdata = VT[i].wdata;
      #2;
      chk(lp_ready == 1, $sformatf("R7 vec %0d ready", i), {31'd0, lp_ready}, 32'd1);
      chk(lp_err == VT[i].err, $sformatf("R%0d vec %0d err", VT[i].req, i),
          {31'd0, lp_err}, {31'd0, VT[i].err});
      if (VT[i].rd)
        chk(lp_rvalid && lp_rdata == VT[i].exp, $sformatf("R%0d vec %0d data", VT[i].req, i),
            lp_rdata, VT[i].exp);
      if (VT[i].err) chk(lp_rvalid == 0, $sformatf("R6 vec %0d rvalid", i), {31'd0, lp_rvalid}, 32'd0);
    end
    lp_idle();
    mode_priv = 1; mode_dsp = 0;

    // R10: high alias normalised to the RAM window
    sb_do(0, 1, 2'd2, 32'hA500_0008, 32'hCAFE_F00D, 0, 32'h0, "R10 alias write");
    lp_drive(0, 0, 2'd2, 32'h0500_0008, 32'h0);
    #2 chk(lp_rvalid && lp_rdata == 32'hCAFE_F00D, "R10 local sees normalised write", lp_rdata, 32'hCAFE_F00D);
    lp_idle();
    // R10: top region kept, misses RAM
    sb_do(0, 1, 2'd2, 32'hE500_0008, 32'h0BAD_0BAD, 1, 32'h0, "R10 top region error");
    sb_do(0, 0, 2'd2, 32'h0500_0008, 32'h0, 0, 32'hCAFE_F00D, "R10 no write from top region");
    // R9: DMA half ok, USB half denied, USB byte ok
    sb_do(0, 1, 2'd1, 32'h0500_000C, 32'h0000_1234, 0, 32'h0, "R9 DMA half");
    sb_do(1, 1, 2'd1, 32'h0500_000A, 32'h9999_0000, 1, 32'h0, "R9 USB half denied");
    sb_do(1, 1, 2'd0, 32'h0500_000F, 32'h7700_0000, 0, 32'h0, "R9 USB byte");
    sb_do(1, 0, 2'd2, 32'h0500_0008, 32'h0, 0, 32'hCAFE_F00D, "R9 R6 half write absent");

    // R11: same-page collision in the system completion cycle
    lp_drive(0, 1, 2'd2, 32'h0500_0400, 32'h4444_5555);
    lp_idle();
    @(negedge clk);
    sb_valid = 1; sb_id = 0; sb_write = 0; sb_size = 2'd2; sb_addr = 32'h0500_0000;
    @(negedge clk);
    @(negedge clk);
    lp_valid = 1; lp_src = 0; lp_write = 0; lp_size = 2'd2; lp_addr = 32'h0500_0004;
    #2;
    chk(sb_ready == 1, "R11 system completes", {31'd0, sb_ready}, 32'd1);
    chk(lp_ready == 0, "R11 same page stall", {31'd0, lp_ready}, 32'd0);
    @(negedge clk);
    sb_valid = 0;
    #2;
    chk(lp_ready == 1 && lp_rdata == 32'hBEEF_AA88, "R11 completes after stall", lp_rdata, 32'hBEEF_AA88);
    lp_idle();
    // R11: different page, no stall
    @(negedge clk);
    sb_valid = 1; sb_addr = 32'h0500_0000;
    @(negedge clk);
    @(negedge clk);
    lp_valid = 1; lp_addr = 32'h0500_0400;
    #2;
    chk(sb_ready == 1 && lp_ready == 1, "R11 other page no stall", {30'd0, sb_ready, lp_ready}, 32'd3);
    chk(lp_rdata == 32'h4444_5555, "R11 other page data", lp_rdata, 32'h4444_5555);
    @(negedge clk);
    sb_valid = 0; lp_valid = 0;
    @(negedge clk);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule